// File: doc/BRIEF.md
# GCD Accelerator with Request and Response Queues

This block computes the greatest common divisor of two unsigned operands of parameter width W and is placed next to a processor as a coprocessor. The processor offers operand pairs on a ready/valid request port. Each accepted pair enters a request queue. A single iterative engine takes one pair at a time and pushes its result into a response queue. The processor collects the result from that queue through a ready/valid response port.

The engine has two parts. A datapath holds two working registers and reports status bits. A control FSM steers the datapath with load, swap and subtract strobes. On each working cycle the engine swaps the registers when the first is smaller than the second. Otherwise it subtracts the second from the first, as long as the second is nonzero. The engine stops once the second register reaches zero, and the first register then holds the result.

Because both queues are present, several requests can be in flight while the engine runs. With the response side stalled, the block can hold DEPTH pairs waiting in the request queue, one finished result held by the engine, and DEPTH results in the response queue.

Top module: `gcd_accel`

## Requirements
- R1: While rst_ni is low and after it is released, req_ready_o is 1 and rsp_valid_o is 0. Both queues are empty and the engine is idle.
- R2: A pair is taken only in a cycle where req_valid_i and req_ready_o are both 1. A result is removed only in a cycle where rsp_valid_o and rsp_ready_i are both 1. With req_valid_i held at 0, no result ever appears.
- R3: For two nonzero operands, the returned result is their greatest common divisor.
- R4: If exactly one operand is zero, the result is the other operand. If both operands are zero, the result is 0.
- R5: Results leave in the order in which their requests were accepted.
- R6: While rsp_ready_i is held at 0, exactly 2*DEPTH+1 pairs are accepted, and req_ready_o then stays at 0.
- R7: While rsp_valid_o is 1 and rsp_ready_i is 0, rsp_valid_o stays at 1 and rsp_data_o keeps its value.
- R8: While the request queue has room, req_ready_o is 1. Starting from an empty block, DEPTH pairs are accepted in DEPTH consecutive cycles.
- R9: Pulling rst_ni low in the middle of traffic discards all pending pairs and results. The next request after reset returns only its own result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | An operand pair is offered |
| req_ready_o | output | 1 | The request queue has room |
| req_a_i | input | W | First operand |
| req_b_i | input | W | Second operand |
| rsp_valid_o | output | 1 | A result is available |
| rsp_ready_i | input | 1 | The consumer takes the result |
| rsp_data_o | output | W | GCD result |

## Verification
Two functions can fall in the same cycle:
- The request queue can accept a new pair in the same cycle that the engine pops the oldest pair from it.
- The response queue can take a finished result in the same cycle that the consumer removes its head.

The bench provokes both overlaps in two ways. It streams a burst of pairs back to back. It also throttles rsp_ready_i in a repeating pattern, so pushes and pops collide at each queue while it is partly full.

The bench judges these overlaps in three ways:
- Every result must come out in request order.
- Every result must equal a GCD computed by an independent modulo-based reference.
- A stalled-response run must stop accepting after exactly 2*DEPTH+1 pairs. This shows that no entry was lost or duplicated when the pointers moved together.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } gcd_state_e;

  // control strobes, FSM -> datapath
  typedef struct packed {
    logic load;
    logic swap;
    logic sub;
  } gcd_ctl_t;

  // status, datapath -> FSM
  typedef struct packed {
    logic b_zero;
    logic a_lt_b;
  } gcd_sts_t;

endpackage

// File: rtl/gcd_fifo.sv
module gcd_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_valid_i,
  output logic             push_ready_o,
  input  logic [WIDTH-1:0] push_data_i,
  output logic             pop_valid_o,
  input  logic             pop_ready_i,
  output logic [WIDTH-1:0] pop_data_o
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [AW-1:0]    wptr_nx, rptr_nx;
  logic             full_q;
  logic             empty;
  logic             wr_en, rd_en;

  assign empty        = (wptr_q == rptr_q) && !full_q;
  assign push_ready_o = !full_q;
  assign pop_valid_o  = !empty;
  assign pop_data_o   = mem_q[rptr_q];

  assign wr_en = push_valid_i && !full_q;
  assign rd_en = pop_ready_i && !empty;

  // DEPTH is a power of two, so pointers wrap naturally
  assign wptr_nx = wr_en ? AW'(wptr_q + 1'b1) : wptr_q;
  assign rptr_nx = rd_en ? AW'(rptr_q + 1'b1) : rptr_q;

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      full_q <= 1'b0;
    end else begin
      wptr_q <= wptr_nx;
      rptr_q <= rptr_nx;
      // pointers meet: full only if the last move was a write
      if (wr_en && !rd_en && (wptr_nx == rptr_nx)) full_q <= 1'b1;
      else if (rd_en && !wr_en)                    full_q <= 1'b0;
    end
  end

endmodule

// File: rtl/gcd_dpath.sv
module gcd_dpath
  import gcd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  gcd_ctl_t     ctl_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  output gcd_sts_t     sts_o,
  output logic [W-1:0] result_o
);

  logic [W-1:0] a_q, b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (ctl_i.load) begin
      a_q <= op_a_i;
      b_q <= op_b_i;
    end else if (ctl_i.swap) begin
      a_q <= b_q;
      b_q <= a_q;
    end else if (ctl_i.sub) begin
      a_q <= a_q - b_q;
    end
  end

  assign sts_o.b_zero = (b_q == '0);
  assign sts_o.a_lt_b = (a_q < b_q);
  assign result_o     = a_q;

endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
  import gcd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_avail_i,
  output logic     req_take_o,
  output logic     rsp_push_o,
  input  logic     rsp_room_i,
  input  gcd_sts_t sts_i,
  output gcd_ctl_t ctl_o
);

  gcd_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    ctl_o      = '0;
    req_take_o = 1'b0;
    rsp_push_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_avail_i) begin
          req_take_o = 1'b1;
          ctl_o.load = 1'b1;
          state_d    = ST_RUN;
        end
      end
      ST_RUN: begin
        if (sts_i.b_zero)      state_d    = ST_DONE;
        else if (sts_i.a_lt_b) ctl_o.swap = 1'b1;
        else                   ctl_o.sub  = 1'b1;
      end
      ST_DONE: begin
        rsp_push_o = 1'b1;
        if (rsp_room_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

endmodule

// File: rtl/gcd_accel.sv
module gcd_accel
  import gcd_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_valid_i,
  output logic         req_ready_o,
  input  logic [W-1:0] req_a_i,
  input  logic [W-1:0] req_b_i,
  output logic         rsp_valid_o,
  input  logic         rsp_ready_i,
  output logic [W-1:0] rsp_data_o
);

  localparam int PW = 2 * W;

  logic [PW-1:0] pair_q;
  logic          pair_avail, pair_take;
  logic          res_push, res_room;
  logic [W-1:0]  res_data;
  gcd_ctl_t      ctl;
  gcd_sts_t      sts;

  gcd_fifo #(.WIDTH(PW), .DEPTH(DEPTH)) i_req_q (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_valid_i (req_valid_i),
    .push_ready_o (req_ready_o),
    .push_data_i  ({req_a_i, req_b_i}),
    .pop_valid_o  (pair_avail),
    .pop_ready_i  (pair_take),
    .pop_data_o   (pair_q)
  );

  gcd_ctrl i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_avail_i (pair_avail),
    .req_take_o  (pair_take),
    .rsp_push_o  (res_push),
    .rsp_room_i  (res_room),
    .sts_i       (sts),
    .ctl_o       (ctl)
  );

  gcd_dpath #(.W(W)) i_dpath (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctl_i    (ctl),
    .op_a_i   (pair_q[PW-1:W]),
    .op_b_i   (pair_q[W-1:0]),
    .sts_o    (sts),
    .result_o (res_data)
  );

  gcd_fifo #(.WIDTH(W), .DEPTH(DEPTH)) i_rsp_q (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_valid_i (res_push),
    .push_ready_o (res_room),
    .push_data_i  (res_data),
    .pop_valid_o  (rsp_valid_o),
    .pop_ready_i  (rsp_ready_i),
    .pop_data_o   (rsp_data_o)
  );

endmodule

// File: rtl/gcd_accel_chk.sv
module gcd_accel_chk #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         req_valid_i,
  input logic         req_ready_o,
  input logic         rsp_valid_o,
  input logic         rsp_ready_i,
  input logic [W-1:0] rsp_data_o
);

  localparam int CAP = 2 * DEPTH + 1;
  localparam int CW  = $clog2(CAP + 1) + 1;

  logic [CW-1:0] outst_q;
  logic          req_fire, rsp_fire;

  assign req_fire = req_valid_i && req_ready_o;
  assign rsp_fire = rsp_valid_o && rsp_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outst_q <= '0;
    else         outst_q <= outst_q + CW'(req_fire) - CW'(rsp_fire);
  end

  // R7
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_data_o));

  // R2
  no_phantom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> outst_q != '0);

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outst_q <= CW'(CAP));

  // R8
  ready_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> outst_q >= CW'(DEPTH));

  // R1
  idle_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outst_q == '0 |-> req_ready_o && !rsp_valid_o);

endmodule

bind gcd_accel gcd_accel_chk #(.W(W), .DEPTH(DEPTH)) i_gcd_accel_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_data_o  (rsp_data_o)
);

// File: tb/test_gcd_accel.sv
module test_gcd_accel;

  localparam int W     = 32;
  localparam int DEPTH = 4;
  localparam int NV    = 12;
  localparam int CAP   = 2 * DEPTH + 1;

  // {a, b, expected gcd}
  localparam logic [3*W-1:0] VEC [NV] = '{
    {32'd12,   32'd18,  32'd6},
    {32'd0,    32'd7,   32'd7},
    {32'd9,    32'd0,   32'd9},
    {32'd0,    32'd0,   32'd0},
    {32'd17,   32'd5,   32'd1},
    {32'd100,  32'd75,  32'd25},
    {32'd1,    32'd1,   32'd1},
    {32'd48,   32'd180, 32'd12},
    {32'd35,   32'd35,  32'd35},
    {32'd1024, 32'd96,  32'd32},
    {32'd270,  32'd192, 32'd6},
    {32'd91,   32'd49,  32'd7}
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic         req_ready_o;
  logic [W-1:0] req_a_i = '0;
  logic [W-1:0] req_b_i = '0;
  logic         rsp_valid_o;
  logic         rsp_ready_i = 1'b0;
  logic [W-1:0] rsp_data_o;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  gcd_accel #(.W(W), .DEPTH(DEPTH)) i_gcd_accel (.*);

  function automatic logic [W-1:0] ref_gcd(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] x = a, y = b, t;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // call at a negedge; returns at the negedge after the transfer, valid still high
  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b);
    req_valid_i = 1'b1;
    req_a_i = a;
    req_b_i = b;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic recv(output logic [W-1:0] d);
    rsp_ready_i = 1'b1;
    while (!rsp_valid_o) @(negedge clk_i);
    d = rsp_data_o;
    @(negedge clk_i);
    rsp_ready_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    logic [W-1:0] d;
    int acc;

    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk("R1 ready in reset", W'(req_ready_o), 1);
    chk("R1 valid in reset", W'(rsp_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 ready after reset", W'(req_ready_o), 1);
    chk("R1 valid after reset", W'(rsp_valid_o), 0);

    // R2: no request offered, data wiggling -> nothing comes out
    for (int i = 0; i < 10; i++) begin
      req_a_i = W'(i * 3 + 1);
      req_b_i = W'(i + 2);
      @(negedge clk_i);
    end
    chk("R2 no phantom result", W'(rsp_valid_o), 0);

    // R3/R4: table, one at a time
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][3*W-1:2*W], VEC[i][2*W-1:W]);
      req_valid_i = 1'b0;
      recv(d);
      chk((i >= 1 && i <= 3) ? "R4 zero operand" : "R3 gcd value", d, VEC[i][W-1:0]);
    end

    // R8: DEPTH pairs accepted on consecutive cycles from empty
    acc = 0;
    for (int i = 0; i < DEPTH; i++) begin
      req_valid_i = 1'b1;
      req_a_i = W'(8 * (i + 1));
      req_b_i = W'(12);
      if (req_ready_o) acc++;
      @(negedge clk_i);
    end
    req_valid_i = 1'b0;
    chk("R8 back-to-back accepts", W'(acc), W'(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      recv(d);
      chk("R5 order after burst", d, ref_gcd(W'(8 * (i + 1)), W'(12)));
    end

    // R6: stall responses, count accepted pairs
    acc = 0;
    for (int c = 0; c < 120; c++) begin
      req_valid_i = 1'b1;
      req_a_i = W'(6 * (acc + 1));
      req_b_i = W'(4 * (acc + 1));
      if (req_ready_o) acc++;
      @(negedge clk_i);
    end
    req_valid_i = 1'b0;
    chk("R6 stalled capacity", W'(acc), W'(CAP));
    chk("R6 ready low when full", W'(req_ready_o), 0);

    // R7: head held while not taken
    d = rsp_data_o;
    repeat (6) @(negedge clk_i);
    chk("R7 valid held", W'(rsp_valid_o), 1);
    chk("R7 data held", rsp_data_o, d);

    // R5: drain in request order
    for (int i = 0; i < CAP; i++) begin
      recv(d);
      chk("R5 drain order", d, W'(2 * (i + 1)));
    end

    // R5 + R3: streaming with throttled consumer
    fork
      begin
        for (int i = 0; i < 20; i++) send(W'(7 * (i + 3)), W'(21 + i));
        req_valid_i = 1'b0;
      end
      begin
        logic [W-1:0] r;
        for (int i = 0; i < 20; i++) begin
          repeat (i % 3) @(negedge clk_i);
          recv(r);
          chk("R5 stream order", r, ref_gcd(W'(7 * (i + 3)), W'(21 + i)));
        end
      end
    join

    // R9: reset in the middle of traffic
    for (int i = 0; i < 3; i++) send(W'(40 + i), W'(6));
    req_valid_i = 1'b0;
    repeat (20) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 valid cleared", W'(rsp_valid_o), 0);
    chk("R9 ready restored", W'(req_ready_o), 1);
    send(W'(15), W'(10));
    req_valid_i = 1'b0;
    recv(d);
    chk("R9 fresh result", d, 5);
    repeat (10) @(negedge clk_i);
    chk("R9 no stale result", W'(rsp_valid_o), 0);

    finish_run();
  end

endmodule